// File: doc/BRIEF.md
# Parallel BCD Array Multiplier

This block multiplies two unsigned decimal significands of N_DIGITS binary-coded decimal digits each and returns the full product of 2*N_DIGITS digits. It is the significand datapath of a decimal floating-point multiplier. With the default N_DIGITS = 16 it serves a 64-bit decimal format. Sign, exponent and rounding are handled outside the block.

Every digit pair of the two operands is multiplied at the same time. Each pair is formed as a small binary product in the range 0..81, which is then split into a tens digit and a units digit. The units digit of operand digit i times operand digit j adds into product column i+j, and its tens digit adds into column i+j+1. A single carry chain then turns the column totals into decimal digits.

The result is captured in a register on the clock edge at which `valid_in` is high. `done` is raised in the next cycle. Between valid strobes the registered product holds its value. Operand digits above 9 are not detected.

Top module: `bcd_array_mult`

## Requirements
- R1: In the cycle after a clock edge with `valid_in` high, `product` equals the decimal product of `a_bcd` and `b_bcd`.
- R2: Each digit-pair product v (0..81) is split into a tens digit v/10 (at most 8) and a units digit v mod 10, so that, for example, 9 x 9 gives the product digits 8 and 1.
- R3: Whenever `done` is high, every 4-bit digit of `product` lies in 0..9.
- R4: For any valid BCD operands, including all-nines times all-nines, the product fits in 2*N_DIGITS digits and no carry leaves the top column.
- R5: `done` is high in exactly the cycle that follows a clock edge with `valid_in` high, and is low otherwise.
- R6: If either operand is zero, the product is all zeros.
- R7: While `valid_in` is low, `product` holds its last value even when the operands change.
- R8: While `rst_n` is low, `product` and `done` are zero.
- R9: Digits are packed 4 bits each, least significant digit in bits [3:0], and digit k in bits [4k+3:4k] of the operand and product buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands valid; the product is captured on this edge |
| a_bcd | input | 4*N_DIGITS | Multiplicand, BCD |
| b_bcd | input | 4*N_DIGITS | Multiplier, BCD |
| done | output | 1 | Product valid, one cycle after valid_in |
| product | output | 8*N_DIGITS | Registered BCD product |

## Verification
The assertions check the following on every cycle:
- the tens and units range of each digit-pair split;
- the absence of a carry out of the top column;
- the digit range of a valid product;
- the one-cycle relation between `valid_in` and `done`;
- the zero-operand result;
- the hold of the product while no strobe arrives.

Only the bench scenarios show that the product equals the true decimal product. They compare the product against a long-hand multiplication model using directed values (all-nines, single digits, carries that cross many columns) and random operands. The bench also checks the reset values.

// File: rtl/bcdmul_pkg.sv
package bcdmul_pkg;
  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  // Split a binary value 0..81 into tens and units: {tens, units}
  function automatic logic [7:0] split_tens(input logic [6:0] v);
    int tens;
    int units;
    tens  = int'(v) / 10;
    units = int'(v) - tens * 10;
    return {4'(tens), 4'(units)};
  endfunction

  // True when every 4-bit digit of a packed vector is 0..9
  function automatic logic digits_are_bcd(input logic [255:0] vec, input int n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < 64; k++) begin
      if (k < n && vec[4*k +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/bcd_digit_mult.sv
module bcd_digit_mult
  import bcdmul_pkg::*;
(
  input  bcd_digit_t x,
  input  bcd_digit_t y,
  output bcd_digit_t tens,
  output bcd_digit_t units
);
  logic [6:0] bin_prod;
  logic [7:0] split;

  always_comb begin
    bin_prod = 7'(x * y);
    split    = split_tens(bin_prod);
    tens     = split[7:4];
    units    = split[3:0];
  end

  // R2: a split of two BCD digits never leaves the digit ranges
  always_comb begin
    if (x <= 4'd9 && y <= 4'd9) begin
      p_split_range_r2: assert (tens <= 4'd8 && units <= 4'd9);
    end
  end
endmodule

// File: rtl/bcd_column_gather.sv
module bcd_column_gather #(
  parameter int N_DIGITS = 16,
  parameter int SUM_W    = 9
) (
  input  logic [4*N_DIGITS*N_DIGITS-1:0] pp_tens,
  input  logic [4*N_DIGITS*N_DIGITS-1:0] pp_units,
  output logic [SUM_W-1:0]               col_sum [2*N_DIGITS]
);
  // Units of pair (i,j) weigh column i+j, tens weigh column i+j+1
  always_comb begin
    for (int k = 0; k < 2*N_DIGITS; k++) col_sum[k] = '0;
    for (int i = 0; i < N_DIGITS; i++) begin
      for (int j = 0; j < N_DIGITS; j++) begin
        col_sum[i+j]   = col_sum[i+j]   + SUM_W'(pp_units[4*(i*N_DIGITS+j) +: 4]);
        col_sum[i+j+1] = col_sum[i+j+1] + SUM_W'(pp_tens[4*(i*N_DIGITS+j) +: 4]);
      end
    end
  end
endmodule

// File: rtl/bcd_column_reduce.sv
module bcd_column_reduce #(
  parameter int N_COLS = 32,
  parameter int SUM_W  = 9
) (
  input  logic [SUM_W-1:0]    col_sum [N_COLS],
  output logic [4*N_COLS-1:0] digits,
  output logic                carry_out
);
  int carry;
  int total;

  // Decimal carry chain from the lowest column upward
  always_comb begin
    carry  = 0;
    total  = 0;
    digits = '0;
    for (int k = 0; k < N_COLS; k++) begin
      total            = int'(col_sum[k]) + carry;
      digits[4*k +: 4] = 4'(total % 10);
      carry            = total / 10;
    end
    carry_out = (carry != 0);
  end
endmodule

// File: rtl/bcd_array_mult.sv
module bcd_array_mult
  import bcdmul_pkg::*;
#(
  parameter int N_DIGITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_in,
  input  logic [4*N_DIGITS-1:0] a_bcd,
  input  logic [4*N_DIGITS-1:0] b_bcd,
  output logic                  done,
  output logic [8*N_DIGITS-1:0] product
);
  localparam int N_COLS  = 2 * N_DIGITS;
  localparam int N_PAIRS = N_DIGITS * N_DIGITS;
  localparam int MAX_COL = 17 * N_DIGITS + 1;
  localparam int SUM_W   = $clog2(MAX_COL + 1);

  logic [4*N_PAIRS-1:0] pp_tens;
  logic [4*N_PAIRS-1:0] pp_units;
  logic [SUM_W-1:0]     col_sum [N_COLS];
  logic [4*N_COLS-1:0]  comb_product;
  logic                 top_carry;

  // All digit pairs at once
  for (genvar i = 0; i < N_DIGITS; i++) begin : g_row
    for (genvar j = 0; j < N_DIGITS; j++) begin : g_col
      bcd_digit_mult u_pair (
        .x     (a_bcd[4*i +: 4]),
        .y     (b_bcd[4*j +: 4]),
        .tens  (pp_tens[4*(i*N_DIGITS+j) +: 4]),
        .units (pp_units[4*(i*N_DIGITS+j) +: 4])
      );
    end
  end

  bcd_column_gather #(.N_DIGITS(N_DIGITS), .SUM_W(SUM_W)) u_gather (
    .pp_tens  (pp_tens),
    .pp_units (pp_units),
    .col_sum  (col_sum)
  );

  bcd_column_reduce #(.N_COLS(N_COLS), .SUM_W(SUM_W)) u_reduce (
    .col_sum   (col_sum),
    .digits    (comb_product),
    .carry_out (top_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= valid_in;
      if (valid_in) product <= comb_product;
    end
  end

  // Named events for the assertions
  logic operands_bcd;
  logic product_bcd;
  logic zero_operand;
  always_comb begin
    operands_bcd = digits_are_bcd(256'(a_bcd), N_DIGITS) && digits_are_bcd(256'(b_bcd), N_DIGITS);
    product_bcd  = digits_are_bcd(256'(product), N_COLS);
    zero_operand = (a_bcd == '0) || (b_bcd == '0);
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && operands_bcd) |-> !top_carry);

  p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product_bcd);

  p_done_after_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !done);

  p_zero_product_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && zero_operand) |=> (product == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(product));
endmodule

// File: tb/test_bcd_array_mult.sv
module test_bcd_array_mult;
  localparam int N  = 16;
  localparam int NT = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid_in = 1'b0;
  logic [4*N-1:0] a_bcd = '0;
  logic [4*N-1:0] b_bcd = '0;
  logic           done;
  logic [8*N-1:0] product;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bcd_array_mult #(.N_DIGITS(N)) i_bcd_array_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (valid_in),
    .a_bcd    (a_bcd),
    .b_bcd    (b_bcd),
    .done     (done),
    .product  (product)
  );

  // Directed vectors: BCD hex literals
  localparam logic [63:0] TA [NT] = '{
    64'h0, 64'h1, 64'h9, 64'h12,
    64'h99999999, 64'h9999999999999999, 64'h123456789, 64'h25};
  localparam logic [63:0] TB [NT] = '{
    64'h1234, 64'h9999999999999999, 64'h9, 64'h34,
    64'h99999999, 64'h9999999999999999, 64'h987654321, 64'h4};
  localparam logic [127:0] TP [NT] = '{
    128'h0, 128'h9999999999999999, 128'h81, 128'h408,
    128'h9999999800000001, 128'h99999999999999980000000000000001,
    128'h121932631112635269, 128'h100};

  // Long-hand decimal model: one multiplier digit per row with a running carry
  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    int acc [2*N];
    int carry;
    int t;
    logic [127:0] r;
    for (int k = 0; k < 2*N; k++) acc[k] = 0;
    for (int j = 0; j < N; j++) begin
      carry = 0;
      for (int i = 0; i < N; i++) begin
        t = acc[i+j] + int'(a[4*i +: 4]) * int'(b[4*j +: 4]) + carry;
        acc[i+j] = t % 10;
        carry = t / 10;
      end
      acc[j+N] = carry;
    end
    r = '0;
    for (int k = 0; k < 2*N; k++) r[4*k +: 4] = 4'(acc[k]);
    return r;
  endfunction

  function automatic logic [63:0] rand_bcd();
    logic [63:0] v;
    for (int k = 0; k < N; k++) v[4*k +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe one operation; return at the negedge after the capture edge
  task automatic run_mul(input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    a_bcd = a;
    b_bcd = b;
    valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0]  ra;
    logic [63:0]  rb;
    logic [127:0] held;
    // R8: reset state
    a_bcd = 64'h9999999999999999;
    b_bcd = 64'h9999999999999999;
    valid_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(product == '0, "R8 product in reset", product, '0);
    chk(done == 1'b0, "R8 done in reset", 128'(done), '0);
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R6 R9: directed table
    for (int t = 0; t < NT; t++) begin
      run_mul(TA[t], TB[t]);
      chk(done == 1'b1, "R5 done after strobe", 128'(done), 128'(1));
      chk(product == TP[t], "R1/R2/R4/R6/R9 table product", product, TP[t]);
    end

    // R5: done drops one cycle after the strobe ends
    @(negedge clk);
    chk(done == 1'b0, "R5 done low without strobe", 128'(done), '0);

    // R7: product holds while operands change without a strobe
    held = product;
    a_bcd = 64'h7777;
    b_bcd = 64'h3;
    repeat (3) @(negedge clk);
    chk(product == held, "R7 hold", product, held);

    // R6: random operand times zero, both orders
    ra = rand_bcd();
    run_mul(ra, 64'h0);
    chk(product == '0, "R6 zero multiplier", product, '0);
    run_mul(64'h0, ra);
    chk(product == '0, "R6 zero multiplicand", product, '0);

    // R1 R3: random vectors against the long-hand model
    for (int t = 0; t < 40; t++) begin
      ra = rand_bcd();
      rb = rand_bcd();
      run_mul(ra, rb);
      chk(product == ref_mul(ra, rb), "R1/R3 random product", product, ref_mul(ra, rb));
    end

    // R5: back-to-back strobes keep done high and update each cycle
    @(negedge clk);
    a_bcd = 64'h5; b_bcd = 64'h7; valid_in = 1'b1;
    @(negedge clk);
    chk(product == 128'h35 && done, "R5 back-to-back first", product, 128'h35);
    a_bcd = 64'h8; b_bcd = 64'h8;
    @(negedge clk);
    chk(product == 128'h64 && done, "R5 back-to-back second", product, 128'h64);
    valid_in = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule